// File: doc/BRIEF.md
# Match-based PWM generator

A timer-driven pulse-width modulator with one up-counter and seven compare registers. Compare register 0 marks the end of every cycle: when the counter equals it, the counter returns to zero. All six outputs therefore share one repetition rate. Each output either follows a single-edge rule or, for the even-numbered outputs, a double-edge rule. A single-edge output rises when a cycle begins and falls at its own compare value. A double-edge output is set by one compare register and cleared by another, in either order, so it produces a positive or a negative pulse.

Every compare register can also raise a sticky flag, force the counter back to zero, or halt the counter. Compare values are written to shadow copies. These copies become active only at a cycle restart, or at any time while the counter is halted. Software drives a plain write port (enable, address, data) and observes the outputs, the flags, the counter value and the running state.

Top module: `edge_pwm`

## Requirements
- R1: After synchronous reset, `count_o` is 0, `run_o` is 0, and all of `pwm_o`, `flag_o` and `irq_o` are 0.
- R2: While running, the counter adds one per clock. After the cycle in which it equals compare 0 (address 0), it reads 0, giving a period of compare0+1 clocks. Bit 0 of address 8 starts the counter (1) or halts it (0).
- R3: Single-edge output `pwm_o[j]` uses compare register j+1 (addresses 1..6) with value D. It goes high on the edge after the counter equals compare 0, and low on the edge after the counter equals D. When both happen on the same edge, the rise wins. It is high for D+1 clocks per period, or for the whole period when D is at least compare 0.
- R4: A single-edge output whose compare value is 0 stays low for the whole period.
- R5: Setting bit p of address 9 (p = 0..2) makes `pwm_o[2p+1]` double-edge. It rises on the edge after a match on compare 2p+1 and falls on the edge after a match on compare 2p+2. A set value below the clear value gives a positive pulse of clear-set clocks.
- R6: In double-edge mode, a clear value below the set value gives a negative pulse. The output stays low for set-clear clocks and is high for the rest of the period.
- R7: When the set and clear compares of a double-edge output match in the same cycle, the output is low afterwards.
- R8: A value written to a compare address while the counter runs does not take effect until the first counter restart caused by compare 0.
- R9: A compare match sets bit i of `flag_o`, and the bit stays set. Writing 1s to address 13 clears the flagged bits, but a match in the same cycle wins. `irq_o` is the OR of the flags whose bit is set in address 10.
- R10: A compare whose bit is set in address 11 returns the counter to 0 on the edge after it matches.
- R11: A compare whose bit is set in address 12 halts the counter on the edge after it matches. `run_o` then reads 0, and both the counter and the outputs hold until the counter is started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0..6 compare, 8 control, 9 pair mode, 10 flag enable, 11 restart action, 12 halt action, 13 flag clear) |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | 6 | Modulated outputs |
| irq_o | output | 1 | Combined interrupt request |
| flag_o | output | 7 | Sticky match flags, one per compare register |
| count_o | output | CNT_W | Current counter value |
| run_o | output | 1 | Counter running |

## Verification
The hardest state to reach is a value change that lands in the middle of a period. The new compare values must stay invisible until the next restart caused by compare 0, while the previous period's edges continue unchanged. The stimulus starts the counter and waits until a known counter value shows at the port. It then rewrites both the period register and an edge register, and probes the output and the wrap point in the current period and in the following one. The halt test is similar. The halt action is armed only after the first period, so that the output is high when the counter stops. The halt action is removed before the counter is restarted, because otherwise the halting compare would match again at once.

// File: rtl/edge_pwm_pkg.sv
`timescale 1ns/1ps
package edge_pwm_pkg;
    localparam int NUM_MATCH = 7;
    localparam int NUM_OUT   = NUM_MATCH - 1;
    localparam int NUM_PAIR  = NUM_OUT / 2;
    localparam int ADDR_W    = 4;

    typedef logic [NUM_MATCH-1:0] mvec_t;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL    = 4'd8,
        ADR_PAIR    = 4'd9,
        ADR_IEN     = 4'd10,
        ADR_RSTACT  = 4'd11,
        ADR_STOPACT = 4'd12,
        ADR_ICLR    = 4'd13
    } cfg_addr_e;

    typedef struct packed {
        mvec_t                 ien;
        mvec_t                 rst_act;
        mvec_t                 stop_act;
        logic [NUM_PAIR-1:0]   pair_en;
    } cfg_t;

    typedef struct packed {
        logic set;
        logic clr;
    } edge_req_t;

    // Resolve the next output level from edge requests; set_wins picks the
    // winner when both requests arrive together.
    function automatic logic next_level(logic cur, edge_req_t req, logic set_wins);
        if (req.set && req.clr) return set_wins;
        if (req.set)            return 1'b1;
        if (req.clr)            return 1'b0;
        return cur;
    endfunction
endpackage

// File: rtl/edge_pwm_regs.sv
`timescale 1ns/1ps
module edge_pwm_regs
    import edge_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              reload,
    input  mvec_t             hit,
    output logic [CNT_W-1:0]  shadow [NUM_MATCH],
    output logic [CNT_W-1:0]  active [NUM_MATCH],
    output cfg_t              cfg,
    output logic              run_wr,
    output logic              run_val,
    output mvec_t             flags
);
    mvec_t clr_mask;

    assign run_wr   = wr_en && (wr_addr == ADR_CTRL);
    assign run_val  = wr_data[0];
    assign clr_mask = (wr_en && (wr_addr == ADR_ICLR)) ? wr_data[NUM_MATCH-1:0] : '0;

    // Compare values: shadow written by software, active used by the timer
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_MATCH; i++) begin
                shadow[i] <= '0;
                active[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_MATCH; i++) begin
                if (wr_en && (wr_addr == ADDR_W'(i)))
                    shadow[i] <= wr_data;
                if (reload)
                    active[i] <= shadow[i];
            end
        end
    end

    // Mode and action configuration, applied immediately
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_PAIR)    cfg.pair_en  <= wr_data[NUM_PAIR-1:0];
            if (wr_addr == ADR_IEN)     cfg.ien      <= wr_data[NUM_MATCH-1:0];
            if (wr_addr == ADR_RSTACT)  cfg.rst_act  <= wr_data[NUM_MATCH-1:0];
            if (wr_addr == ADR_STOPACT) cfg.stop_act <= wr_data[NUM_MATCH-1:0];
        end
    end

    // Sticky flags: a new match beats a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_mask) | hit;
    end
endmodule

// File: rtl/edge_pwm_timer.sv
`timescale 1ns/1ps
module edge_pwm_timer
    import edge_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_wr,
    input  logic             run_val,
    input  logic [CNT_W-1:0] active [NUM_MATCH],
    input  mvec_t            rst_mask,
    input  mvec_t            stop_mask,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output mvec_t            hit
);
    logic do_rst;
    logic stop_eff;

    always_comb begin
        for (int i = 0; i < NUM_MATCH; i++)
            hit[i] = run && (cnt == active[i]);
    end

    assign do_rst   = hit[0] || (|(hit & rst_mask));
    assign stop_eff = (|(hit & stop_mask)) && !run_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else begin
            if (run_wr)        run <= run_val;
            else if (stop_eff) run <= 1'b0;

            if (do_rst)                 cnt <= '0;
            else if (run && !stop_eff)  cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/edge_pwm_chan.sv
`timescale 1ns/1ps
module edge_pwm_chan
    import edge_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit_cyc,
    input  logic hit_set,
    input  logic hit_clr,
    input  logic zero_next,
    input  logic dual_sel,
    output logic pwm
);
    edge_req_t req;
    logic      set_wins;

    always_comb begin
        if (dual_sel) begin
            req.set  = hit_set;
            req.clr  = hit_clr;
            set_wins = 1'b0;
        end else begin
            req.set  = hit_cyc && !zero_next;
            req.clr  = hit_clr;
            set_wins = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pwm <= 1'b0;
        else     pwm <= next_level(pwm, req, set_wins);
    end
endmodule

// File: rtl/edge_pwm.sv
`timescale 1ns/1ps
module edge_pwm
    import edge_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_OUT-1:0] pwm_o,
    output logic              irq_o,
    output logic [NUM_MATCH-1:0] flag_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              run_o
);
    logic [CNT_W-1:0] shadow [NUM_MATCH];
    logic [CNT_W-1:0] active [NUM_MATCH];
    cfg_t             cfg;
    logic             run_wr;
    logic             run_val;
    mvec_t            flags;
    mvec_t            hit;
    logic [CNT_W-1:0] cnt;
    logic             run;

    edge_pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .reload  (!run || hit[0]),
        .hit     (hit),
        .shadow  (shadow),
        .active  (active),
        .cfg     (cfg),
        .run_wr  (run_wr),
        .run_val (run_val),
        .flags   (flags)
    );

    edge_pwm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_wr    (run_wr),
        .run_val   (run_val),
        .active    (active),
        .rst_mask  (cfg.rst_act),
        .stop_mask (cfg.stop_act),
        .cnt       (cnt),
        .run       (run),
        .hit       (hit)
    );

    for (genvar n = 1; n < NUM_MATCH; n++) begin : g_ch
        logic dsel;
        if (n % 2 == 0) begin : g_pair
            assign dsel = cfg.pair_en[n/2-1];
        end else begin : g_solo
            assign dsel = 1'b0;
        end
        edge_pwm_chan u_ch (
            .clk       (clk),
            .rst       (rst),
            .hit_cyc   (hit[0]),
            .hit_set   (hit[n-1]),
            .hit_clr   (hit[n]),
            .zero_next (shadow[n] == '0),
            .dual_sel  (dsel),
            .pwm       (pwm_o[n-1])
        );
    end

    assign irq_o   = |(flags & cfg.ien);
    assign flag_o  = flags;
    assign count_o = cnt;
    assign run_o   = run;
endmodule

// File: rtl/edge_pwm_sva.sv
`timescale 1ns/1ps
module edge_pwm_sva
    import edge_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [NUM_MATCH-1:0] clr_bits,
    input logic [NUM_OUT-1:0]   pwm_o,
    input logic                 irq_o,
    input logic [NUM_MATCH-1:0] flag_o,
    input logic [CNT_W-1:0]     count_o,
    input logic                 run_o,
    input logic [NUM_MATCH-1:0] hit,
    input logic [NUM_MATCH-1:0] rst_act,
    input logic [NUM_PAIR-1:0]  pair_en
);
    logic [NUM_MATCH-1:0] clr_q;

    always_ff @(posedge clk) begin
        if (rst) clr_q <= '0;
        else     clr_q <= (wr_en && (wr_addr == ADR_ICLR)) ? clr_bits : '0;
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        $past(hit[0]) |-> (count_o == '0))
        else $error("counter did not return to zero after period match");

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(run_o) && run_o && (count_o != '0)) |-> (count_o == $past(count_o) + CNT_W'(1)))
        else $error("running counter did not advance by one");

    assert_match_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(|(hit & rst_act)) |-> (count_o == '0))
        else $error("restart action did not clear the counter");

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(run_o) && !run_o) |-> ($stable(count_o) && $stable(pwm_o)))
        else $error("halted counter or outputs moved");

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        &(~$past(flag_o) | flag_o | clr_q))
        else $error("flag dropped without a clear write");

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
        &(~$past(hit) | flag_o))
        else $error("match did not set its flag");

    assert_irq_src_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|flag_o))
        else $error("interrupt without any flag");

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(pair_en[k]) && $past(hit[2*k+2])) |-> !pwm_o[2*k+1])
            else $error("double-edge output high after its clear match");
    end
endmodule

bind edge_pwm edge_pwm_sva #(.CNT_W(CNT_W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .clr_bits (wr_data[edge_pwm_pkg::NUM_MATCH-1:0]),
    .pwm_o    (pwm_o),
    .irq_o    (irq_o),
    .flag_o   (flag_o),
    .count_o  (count_o),
    .run_o    (run_o),
    .hit      (hit),
    .rst_act  (cfg.rst_act),
    .pair_en  (cfg.pair_en)
);

// File: tb/edge_pwm_tb.sv
`timescale 1ns/1ps
module edge_pwm_tb;
    import edge_pwm_pkg::*;

    localparam int CNT_W = 16;
    localparam int NVEC  = 7;
    // {period match, edge match, expected high clocks, expected period}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0903040A, 32'h0900000A, 32'h04040505, 32'h0C140D0D,
        32'h02010203, 32'h01010202, 32'h06050607
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [NUM_OUT-1:0]   pwm_o;
    logic                 irq_o;
    logic [NUM_MATCH-1:0] flag_o;
    logic [CNT_W-1:0]     count_o;
    logic                 run_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    edge_pwm #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_o(pwm_o), .irq_o(irq_o), .flag_o(flag_o), .count_o(count_o), .run_o(run_o)
    );

    always #2 clk = ~clk;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input int d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d[CNT_W-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_count(input int v);
        do @(negedge clk); while (int'(count_o) != v);
    endtask

    task automatic check_reset_state(input string tag);
        check_eq({tag, " R1 count"}, int'(count_o), 0);
        check_eq({tag, " R1 run"}, int'(run_o), 0);
        check_eq({tag, " R1 pwm"}, int'(pwm_o), 0);
        check_eq({tag, " R1 flags"}, int'(flag_o), 0);
        check_eq({tag, " R1 irq"}, int'(irq_o), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                n_err++;
                n_chk++;
                $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check_reset_state("power-up");

        // Vector table: single-edge output pwm_o[0] against period register
        for (int v = 0; v < NVEC; v++) begin
            int m0, m1, eh, ep, highs, zeros, maxc;
            m0 = int'(VEC[v][31:24]);
            m1 = int'(VEC[v][23:16]);
            eh = int'(VEC[v][15:8]);
            ep = int'(VEC[v][7:0]);
            highs = 0; zeros = 0; maxc = 0;
            do_reset();
            wr(4'd0, m0);
            wr(4'd1, m1);
            wr(ADR_CTRL, 1);
            wait_count(m0);
            wait_count(m0);
            for (int c = 0; c <= m0; c++) begin
                @(negedge clk);
                if (pwm_o[0]) highs++;
                if (count_o == '0) zeros++;
                if (int'(count_o) > maxc) maxc = int'(count_o);
            end
            check_eq((m1 == 0) ? "R4 zero value high clocks" : "R3 single-edge high clocks", highs, eh);
            check_eq("R2 one wrap per period", zeros, 1);
            check_eq("R2 period length", maxc + 1, ep);
        end

        // R5 R6 R7: double-edge pairs
        begin
            int h1, h3, h5, p1_at3, p3_at3, p3_at8;
            h1 = 0; h3 = 0; h5 = 0; p1_at3 = 0; p3_at3 = 1; p3_at8 = 0;
            do_reset();
            wr(4'd0, 9);
            wr(4'd1, 2); wr(4'd2, 6);
            wr(4'd3, 7); wr(4'd4, 2);
            wr(4'd5, 4); wr(4'd6, 4);
            wr(ADR_PAIR, 7);
            wr(ADR_CTRL, 1);
            wait_count(9);
            wait_count(9);
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (pwm_o[1]) h1++;
                if (pwm_o[3]) h3++;
                if (pwm_o[5]) h5++;
                if (count_o == 16'd3) begin p1_at3 = int'(pwm_o[1]); p3_at3 = int'(pwm_o[3]); end
                if (count_o == 16'd8) p3_at8 = int'(pwm_o[3]);
            end
            check_eq("R5 positive pulse width", h1, 4);
            check_eq("R5 high after set match", p1_at3, 1);
            check_eq("R6 negative pulse high clocks", h3, 5);
            check_eq("R6 low after clear match", p3_at3, 0);
            check_eq("R6 high after set match", p3_at8, 1);
            check_eq("R7 coincident set and clear", h5, 0);
        end

        // R8: shadowed compare writes during a running period
        do_reset();
        wr(4'd0, 9);
        wr(4'd1, 3);
        wr(ADR_CTRL, 1);
        wait_count(1);
        wr(4'd1, 6);
        wr(4'd0, 5);
        wait_count(5);
        check_eq("R8 old edge kept in current period", int'(pwm_o[0]), 0);
        wait_count(9);
        @(negedge clk);
        check_eq("R8 old period kept", int'(count_o), 0);
        wait_count(5);
        check_eq("R8 new edge after restart", int'(pwm_o[0]), 1);
        @(negedge clk);
        check_eq("R8 new period after restart", int'(count_o), 0);

        // R9: sticky flags, clear, interrupt enable
        do_reset();
        wr(4'd0, 9);
        wr(4'd2, 4);
        wr(ADR_IEN, 1 << 2);
        wr(ADR_CTRL, 1);
        wait_count(6);
        check_eq("R9 flag set by match", int'(flag_o[2]), 1);
        check_eq("R9 irq from enabled flag", int'(irq_o), 1);
        wr(ADR_ICLR, 1 << 2);
        check_eq("R9 flag cleared by write", int'(flag_o[2]), 0);
        check_eq("R9 irq drops after clear", int'(irq_o), 0);
        check_eq("R9 disabled flag still set", int'(flag_o[1]), 1);
        wait_count(5);
        check_eq("R9 flag set again next period", int'(flag_o[2]), 1);

        // R10: restart action on compare 1
        begin
            int maxc;
            maxc = 0;
            do_reset();
            wr(4'd0, 9);
            wr(4'd1, 5);
            wr(ADR_RSTACT, 1 << 1);
            wr(ADR_CTRL, 1);
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (int'(count_o) > maxc) maxc = int'(count_o);
            end
            check_eq("R10 counter limited by restart action", maxc, 5);
        end

        // R11: halt action, hold, restart
        do_reset();
        wr(4'd0, 9);
        wr(4'd1, 8);
        wr(4'd3, 6);
        wr(ADR_CTRL, 1);
        wait_count(8);
        wr(ADR_STOPACT, 1 << 3);
        wait_count(6);
        repeat (10) @(negedge clk);
        check_eq("R11 counter held", int'(count_o), 6);
        check_eq("R11 run cleared", int'(run_o), 0);
        check_eq("R11 output held high", int'(pwm_o[0]), 1);
        wr(ADR_STOPACT, 0);
        wr(ADR_CTRL, 1);
        check_eq("R11 run after restart", int'(run_o), 1);
        @(negedge clk);
        check_eq("R11 counter resumes", int'(count_o), 7);

        // R1 again: reset while active
        do_reset();
        check_reset_state("mid-run");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule